// File: doc/BRIEF.md
# Clock Phase Sweep Calibrator

This block finds a good latching point for a parallel data bus whose lanes are all captured by one shared, phase-adjustable clock. It drives a PLL that can shift its output phase by one increment per request. It walks that phase once around the whole period. At each position it lets the PLL settle, then checks the captured data against a fixed training word for a fixed window. It records which positions are clean and, once the sweep is over, moves the PLL to the centre of the widest clean stretch.

The same clock edge can also feed a second capture on the opposite edge. When that option is enabled, a second pass map is kept for that stream and a separate best position is reported for it. The PLL itself follows only the primary stream. Software or a sequencer raises `start_i`, waits for `done_o`, and reads `phase_o` and `fail_o`.

Top module: `pss_phase_cal`

## Requirements
- R1: While reset is held and right after it, busy_o, done_o, fail_o, step_req_o, fall_fail_o are 0 and phase_o, fall_phase_o are 0.
- R2: A start_i pulse seen while busy_o is low raises busy_o on the next clock edge and clears done_o and fail_o. start_i while busy_o is high is ignored and the sweep in progress carries on unchanged.
- R3: step_req_o stays high until a cycle in which step_ack_i is high. Each acknowledged request advances the PLL by exactly one phase index, modulo 16. step_req_o is low in the cycle after every acknowledgement.
- R4: After the sweep begins and after each acknowledged step, the first 64 sample cycles are not compared, so bad data in that interval has no effect on the result.
- R5: Each phase is judged over 128 consecutive sample cycles. A sample matches only when every lane equals the training word 8'hA5, and one mismatching sample in the window marks that phase as failing.
- R6: One sweep measures all 16 phase indices exactly once, starting at the phase the PLL holds when start_i is accepted, using 15 forward steps.
- R7: The chosen index is start + (len-1)/2, modulo 16, of the longest run of passing indices. Equal lengths go to the run whose first index is lowest. If all 16 pass, the chosen index is 7.
- R8: A run that crosses from index 15 to index 0 counts as one run, and its first index is the one above 15's failing neighbour.
- R9: After the sweep the block issues forward steps until the PLL sits at the chosen index. Then busy_o falls and done_o rises in the same cycle, with phase_o set to that index. done_o, phase_o and fail_o then hold until the next accepted start.
- R10: If no index passes, fail_o is set with done_o, phase_o is 0 and the PLL is stepped to index 0.
- R11: With the second stream enabled, fall_phase_o and fall_fail_o report the same choice rule applied to fall_data_i, with fall_phase_o 0 when fall_fail_o is 1. The PLL position is not affected by this stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration sweep |
| step_req_o | output | 1 | Request one phase increment from the PLL |
| step_ack_i | input | 1 | PLL acknowledges a phase increment |
| rise_data_i | input | LANES | Lanes captured on the primary edge |
| fall_data_i | input | LANES | Lanes captured on the opposite edge |
| busy_o | output | 1 | Sweep or return in progress |
| done_o | output | 1 | Calibration finished, result valid |
| fail_o | output | 1 | No passing phase on the primary stream |
| phase_o | output | $clog2(STEPS) | Chosen phase index for the primary stream |
| fall_phase_o | output | $clog2(STEPS) | Best phase index for the opposite-edge stream |
| fall_fail_o | output | 1 | No passing phase on the opposite-edge stream |

## Verification
Two events can land on the same clock edge. A PLL acknowledgement can arrive on the first edge at which the request is visible. A start request can arrive while the block is busy. The PLL model in the bench can answer with no added latency or with several cycles of delay, and it counts every step it grants. A start pulse is injected in the middle of a sweep. Each case is judged by the number of steps the model granted, by the final model phase matching phase_o, and by the reported indices matching the hand-computed values.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MEASURE,
        ST_ADVANCE,
        ST_RET_CHK,
        ST_RET_STEP,
        ST_FINISH
    } cal_state_e;

endpackage

// File: rtl/pss_err_count.sv
module pss_err_count #(
    parameter int              LANES = 8,
    parameter logic [LANES-1:0] WORD = 8'hA5,
    parameter int              CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic [LANES-1:0] data_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign hit_o   = enable_i && (data_i != WORD);
    assign count_o = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (hit_o && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/pss_run_pick.sv
module pss_run_pick #(
    parameter int STEPS = 16,
    parameter int IDX_W = 4
) (
    input  logic [STEPS-1:0] map_i,
    output logic             found_o,
    output logic [IDX_W-1:0] mid_o
);

    int   best_len;
    int   run_len;
    logic in_run;

    assign found_o = |map_i;

    always_comb begin
        best_len = 0;
        run_len  = 0;
        in_run   = 1'b0;
        mid_o    = '0;
        if (&map_i) begin
            mid_o = IDX_W'((STEPS - 1) / 2);
        end else begin
            for (int s = 0; s < STEPS; s++) begin
                if (map_i[s] && !map_i[(s + STEPS - 1) % STEPS]) begin
                    run_len = 0;
                    in_run  = 1'b1;
                    for (int k = 0; k < STEPS; k++) begin
                        if (in_run && map_i[(s + k) % STEPS]) run_len = run_len + 1;
                        else                                  in_run  = 1'b0;
                    end
                    if (run_len > best_len) begin
                        best_len = run_len;
                        mid_o    = IDX_W'((s + (run_len - 1) / 2) % STEPS);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pss_phase_cal.sv
module pss_phase_cal
    import pss_pkg::*;
#(
    parameter int               LANES      = 8,
    parameter int               STEPS      = 16,
    parameter int               SETTLE_CYC = 64,
    parameter int               WINDOW_CYC = 128,
    parameter logic [LANES-1:0] TRAIN_WORD = 8'hA5,
    parameter bit               DUAL_EDGE  = 1'b1,
    localparam int              IDX_W      = $clog2(STEPS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             step_req_o,
    input  logic             step_ack_i,
    input  logic [LANES-1:0] rise_data_i,
    input  logic [LANES-1:0] fall_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [IDX_W-1:0] phase_o,
    output logic [IDX_W-1:0] fall_phase_o,
    output logic             fall_fail_o
);

    localparam int TMR_MAX = (SETTLE_CYC > WINDOW_CYC) ? SETTLE_CYC : WINDOW_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int CNT_W   = $clog2(WINDOW_CYC + 1);

    typedef struct packed {
        cal_state_e       st;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] swept;
        logic [TMR_W-1:0] tmr;
        logic [STEPS-1:0] map_r;
        logic [STEPS-1:0] map_f;
        logic             done;
        logic             fail;
        logic [IDX_W-1:0] phase;
        logic [IDX_W-1:0] fphase;
        logic             ffail;
    } regs_t;

    regs_t r_d, r_q;

    logic             cnt_clr, cnt_en;
    logic             r_hit, f_hit;
    logic [CNT_W-1:0] r_cnt, f_cnt;
    logic             r_clean, f_clean;
    logic             r_found, f_found;
    logic [IDX_W-1:0] r_mid, f_mid;
    logic [IDX_W-1:0] target;

    assign cnt_clr = (r_q.st == ST_SETTLE);
    assign cnt_en  = (r_q.st == ST_MEASURE);

    pss_err_count #(.LANES(LANES), .WORD(TRAIN_WORD), .CNT_W(CNT_W)) u_err_rise (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (cnt_clr),
        .enable_i (cnt_en),
        .data_i   (rise_data_i),
        .hit_o    (r_hit),
        .count_o  (r_cnt)
    );

    pss_run_pick #(.STEPS(STEPS), .IDX_W(IDX_W)) u_pick_rise (
        .map_i   (r_q.map_r),
        .found_o (r_found),
        .mid_o   (r_mid)
    );

    assign r_clean = (r_cnt == '0) && !r_hit;

    if (DUAL_EDGE) begin : g_fall
        pss_err_count #(.LANES(LANES), .WORD(TRAIN_WORD), .CNT_W(CNT_W)) u_err_fall (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clear_i  (cnt_clr),
            .enable_i (cnt_en),
            .data_i   (fall_data_i),
            .hit_o    (f_hit),
            .count_o  (f_cnt)
        );
        pss_run_pick #(.STEPS(STEPS), .IDX_W(IDX_W)) u_pick_fall (
            .map_i   (r_q.map_f),
            .found_o (f_found),
            .mid_o   (f_mid)
        );
        assign f_clean = (f_cnt == '0) && !f_hit;
    end else begin : g_no_fall
        logic [LANES-1:0] fall_unused;
        assign fall_unused = fall_data_i;
        assign f_hit   = 1'b0;
        assign f_cnt   = '0;
        assign f_found = 1'b0;
        assign f_mid   = '0;
        assign f_clean = 1'b0;
    end

    assign target = r_found ? r_mid : '0;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(STEPS - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_SETTLE;
                    r_d.tmr   = '0;
                    r_d.swept = '0;
                    r_d.map_r = '0;
                    r_d.map_f = '0;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.ffail = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (r_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                    r_d.st  = ST_MEASURE;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_MEASURE: begin
                if (r_q.tmr == TMR_W'(WINDOW_CYC - 1)) begin
                    r_d.map_r[r_q.cur] = r_clean;
                    r_d.map_f[r_q.cur] = f_clean;
                    r_d.tmr            = '0;
                    r_d.st = (r_q.swept == IDX_W'(STEPS - 1)) ? ST_RET_CHK : ST_ADVANCE;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_ADVANCE: begin
                if (step_ack_i) begin
                    r_d.cur   = next_idx(r_q.cur);
                    r_d.swept = r_q.swept + 1'b1;
                    r_d.st    = ST_SETTLE;
                end
            end
            ST_RET_CHK: begin
                r_d.st = (r_q.cur == target) ? ST_FINISH : ST_RET_STEP;
            end
            ST_RET_STEP: begin
                if (step_ack_i) begin
                    r_d.cur = next_idx(r_q.cur);
                    r_d.st  = ST_RET_CHK;
                end
            end
            ST_FINISH: begin
                r_d.done   = 1'b1;
                r_d.fail   = !r_found;
                r_d.phase  = target;
                r_d.fphase = f_found ? f_mid : '0;
                r_d.ffail  = DUAL_EDGE && !f_found;
                r_d.st     = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_req_o   = (r_q.st == ST_ADVANCE) || (r_q.st == ST_RET_STEP);
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign fail_o       = r_q.fail;
    assign phase_o      = r_q.phase;
    assign fall_phase_o = r_q.fphase;
    assign fall_fail_o  = r_q.ffail;

endmodule

// File: rtl/pss_phase_cal_chk.sv
module pss_phase_cal_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             step_req_o,
    input logic             step_ack_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             fail_o,
    input logic [IDX_W-1:0] phase_o,
    input logic [IDX_W-1:0] fall_phase_o,
    input logic             fall_fail_o
);

    AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_req_o && !step_ack_i) |=> step_req_o); // R3

    AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_req_o && step_ack_i) |=> !step_req_o); // R3

    AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !step_req_o); // R9

    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && $past(done_o)) |-> ($stable(phase_o) && $stable(fail_o))); // R9

    AST_FAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> (phase_o == '0)); // R10

    AST_FALL_FAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_fail_o |-> (fall_phase_o == '0)); // R11

endmodule

bind pss_phase_cal pss_phase_cal_chk #(.IDX_W(IDX_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .step_req_o   (step_req_o),
    .step_ack_i   (step_ack_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .phase_o      (phase_o),
    .fall_phase_o (fall_phase_o),
    .fall_fail_o  (fall_fail_o)
);

// File: tb/pss_phase_cal_test.sv
module pss_phase_cal_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] WORD = 8'hA5;

    typedef struct packed {
        logic [15:0] rg;
        logic [15:0] rgl;
        logic [15:0] fg;
        logic [3:0]  eph;
        logic        efail;
        logic [3:0]  efph;
        logic        effail;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{16'h00F0, 16'h0000, 16'h0F00, 4'd5,  1'b0, 4'd9,  1'b0},
        '{16'hC003, 16'h0000, 16'h0000, 4'd15, 1'b0, 4'd0,  1'b1},
        '{16'hFFFF, 16'h0000, 16'hFFFF, 4'd7,  1'b0, 4'd7,  1'b0},
        '{16'h0000, 16'h0000, 16'h0001, 4'd0,  1'b1, 4'd0,  1'b0},
        '{16'h0303, 16'h0000, 16'h00E0, 4'd0,  1'b0, 4'd6,  1'b0},
        '{16'h3F0E, 16'h0F00, 16'h8001, 4'd2,  1'b0, 4'd15, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       step_ack = 1'b0;
    logic [7:0] rise_data = 8'h00;
    logic [7:0] fall_data = 8'h00;
    logic       step_req, busy, done, fail, fall_fail;
    logic [3:0] phase, fall_phase;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int model_ph = 0;
    int acks = 0;
    int since_ack = 1000;
    int wait_ctr = 0;
    int ack_lat = 0;
    bit dirty = 1'b0;
    logic [15:0] m_rg = '0, m_rgl = '0, m_fg = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pss_phase_cal uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .step_req_o   (step_req),
        .step_ack_i   (step_ack),
        .rise_data_i  (rise_data),
        .fall_data_i  (fall_data),
        .busy_o       (busy),
        .done_o       (done),
        .fail_o       (fail),
        .phase_o      (phase),
        .fall_phase_o (fall_phase),
        .fall_fail_o  (fall_fail)
    );

    // PLL and capture model, acting on the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (since_ack < 1000) since_ack = since_ack + 1;
        if (step_ack) begin
            step_ack = 1'b0;
        end else if (step_req && rst_n) begin
            if (wait_ctr < ack_lat) begin
                wait_ctr = wait_ctr + 1;
            end else begin
                step_ack  = 1'b1;
                model_ph  = (model_ph + 1) % 16;
                acks      = acks + 1;
                since_ack = 0;
                wait_ctr  = 0;
            end
        end
        if (!m_rg[model_ph] || (m_rgl[model_ph] && (cyc % 128 == 5)) || (dirty && since_ack < 50))
            rise_data = ~WORD;
        else
            rise_data = WORD;
        if (!m_fg[model_ph] || (dirty && since_ack < 50))
            fall_data = ~WORD;
        else
            fall_data = WORD;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_case(input vec_t v, input bit mid_start, input string tag);
        int p0, a0, ret;
        bit ok;
        m_rg = v.rg; m_rgl = v.rgl; m_fg = v.fg;
        p0 = model_ph;
        a0 = acks;
        @(negedge clk);
        start = 1'b1;
        since_ack = 0;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R2 busy after start"}, busy, 1);
        chk({tag, " R2 done cleared"}, done, 0);
        if (mid_start) begin
            repeat (700) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk({tag, " R9 done reached"}, ok, 1);
        chk({tag, " R7 R8 phase_o"}, phase, v.eph);
        chk({tag, " R10 fail_o"}, fail, v.efail);
        chk({tag, " R11 fall_phase_o"}, fall_phase, v.efph);
        chk({tag, " R11 fall_fail_o"}, fall_fail, v.effail);
        chk({tag, " R9 PLL at chosen phase"}, model_ph, v.eph);
        chk({tag, " R9 busy low"}, busy, 0);
        ret = (v.eph - p0 + 1 + 32) % 16;
        chk({tag, " R3 R6 step count"}, acks - a0, 15 + ret);
        repeat (5) @(negedge clk);
        chk({tag, " R9 done held"}, done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 req in reset", step_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fail after reset", fail, 0);
        chk("R1 phase after reset", phase, 0);
        chk("R1 fall outputs after reset", {fall_fail, fall_phase}, 0);

        for (int i = 0; i < NVEC; i++) begin
            ack_lat = (i % 2 == 0) ? 0 : 3;
            run_case(VEC[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R4: bad data only during settle intervals, slow acknowledgements
        dirty = 1'b1;
        ack_lat = 4;
        run_case('{16'h00F0, 16'h0000, 16'h0F00, 4'd5, 1'b0, 4'd9, 1'b0}, 1'b0, "R4 settle");
        dirty = 1'b0;

        // R5: one glitch per window on every otherwise good phase
        ack_lat = 0;
        run_case('{16'hFFFF, 16'h00FF, 16'h0000, 4'd11, 1'b0, 4'd0, 1'b1}, 1'b0, "R5 glitch");

        // R2: start pulsed while busy must be ignored
        run_case('{16'h0FF0, 16'h0000, 16'h0FF0, 4'd7, 1'b0, 4'd7, 1'b0}, 1'b1, "R2 busy start");

        // R1: reset in the middle of a sweep
        m_rg = 16'hFFFF;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        model_ph = 0;
        chk("R1 busy after mid reset", busy, 0);
        chk("R1 req after mid reset", step_req, 0);
        chk("R1 phase after mid reset", phase, 0);
        chk("R1 done after mid reset", done, 0);
        rst_n = 1'b1;
        ack_lat = 2;
        run_case('{16'h8001, 16'h0000, 16'h0000, 4'd15, 1'b0, 4'd0, 1'b1}, 1'b0, "R8 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule